// File: doc/BRIEF.md
# OTP configuration burn sequencer

This block sits in front of a one-time-programmable fuse store that holds a few bytes of configuration. After reset it waits for the supply-good input, then copies the newest burned bank into a set of working registers and marks them valid. Software reads and writes the working registers over a simple byte-wide register bus. It can then make those values permanent by burning them into the next unused bank.

Three banks exist. Bank 0 carries the factory image, and the user can burn the other two, one each time. A thermometer-coded pointer in the fuse store records which banks are in use. The block reads that pointer to pick the bank to load, and advances it with each burn. A burn needs four things: an unlock bit set beforehand, the burn command byte, the output-enable pin low, and a pointer that is not full. While a burn is running the block stays busy for a programmable number of cycles and then reports that it is done.

Top module: `otp_burn_seq`

## Requirements
- R1: While `supply_ok_i` has not yet been seen high since reset, `cfg_valid_o` is 0, `cfg_o` is all zeros, and register bus writes have no effect.
- R2: In the first cycle that `supply_ok_i` is high, the working registers are loaded from the bank that the fuse pointer selects (3'b001 selects bank 0, 3'b011 selects bank 1, 3'b111 selects bank 2). `cfg_valid_o` rises on that same edge.
- R3: Address 0x20 reads the pointer in bits [5:3], with all other bits 0. Writes to 0x20 are ignored.
- R4: Address 0x1D reads the unlock flag in bit 1, with all other bits 0. Reset clears the flag, and a write to 0x1D loads the flag from data bit 1.
- R5: A burn starts only on a write of 0x15 to address 0x2B, and only while the unlock flag is 1, `out_en_i` is 0 and the pointer is not 3'b111. Any other attempt writes no bank and does not set busy.
- R6: On the edge after an accepted command, `otp_wr_o` pulses for exactly one cycle. `otp_wr_bank_o` gives the next free bank and `otp_wdata_o` gives the working registers. On that same edge the pointer shifts in a 1 and the unlock flag clears.
- R7: `busy_o` stays high for WAIT_CYCLES cycles from the start of the burn, and then `done_o` rises. Address 0x2C reads {valid, done, busy} in bits [2:0].
- R8: Register bus writes received while `busy_o` is high have no effect.
- R9: After a reset and a new supply-good event, the working registers hold exactly the values that the last burn wrote.
- R10: Addresses 0 to NUM_REGS-1 are read/write working registers. Register k is `cfg_o[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above start-up threshold |
| out_en_i | input | 1 | Output enable pin level |
| wr_en_i | input | 1 | Register bus write strobe |
| addr_i | input | 8 | Register bus address (read and write) |
| wdata_i | input | 8 | Register bus write data |
| rdata_o | output | 8 | Register bus read data, combinational from addr_i |
| otp_ptr_i | input | 3 | Pointer value held in the fuse store |
| otp_rd_bank_o | output | 2 | Bank selected for loading |
| otp_rdata_i | input | NUM_REGS*8 | Contents of the selected bank |
| otp_wr_o | output | 1 | One-cycle bank program pulse |
| otp_wr_bank_o | output | 2 | Bank being programmed |
| otp_wdata_o | output | NUM_REGS*8 | Data to program |
| cfg_o | output | NUM_REGS*8 | Working registers |
| cfg_valid_o | output | 1 | Working registers loaded |
| busy_o | output | 1 | Burn in progress |
| done_o | output | 1 | Last burn completed |

## Verification
The load happens on the first edge that sees `supply_ok_i` high, so `cfg_valid_o` and `cfg_o` change one cycle after the supply input rises. An accepted command raises `otp_wr_o` and `busy_o` one edge after the write, and `done_o` follows WAIT_CYCLES edges after that. A register write shows up at the next edge, while reads depend only on the address. The bench's model takes the same sampled inputs at each rising edge and is compared with the registered outputs at the falling edge. Reads are checked combinationally just after a falling edge. A fuse model that can only set bits then shows that the burned data comes back after a power cycle.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  localparam logic [7:0] ADDR_UNLOCK = 8'h1D;
  localparam logic [7:0] ADDR_PTR    = 8'h20;
  localparam logic [7:0] ADDR_CMD    = 8'h2B;
  localparam logic [7:0] ADDR_STAT   = 8'h2C;
  localparam logic [7:0] CMD_BURN    = 8'h15;

  typedef logic [2:0] ptr_t;
  localparam ptr_t PTR_FULL = 3'b111;

  function automatic logic [1:0] bank_of_ptr(input ptr_t p);
    case (p)
      3'b011:  return 2'd1;
      3'b111:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/otp_cfg_regs.sv
module otp_cfg_regs #(
  parameter int NUM_REGS = 4,
  parameter int DW       = 8,
  localparam int CW      = NUM_REGS * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_data_i,
  input  logic          wr_i,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cfg_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (load_i)                      q <= load_data_i[g*DW +: DW];
      else if (wr_i && addr_i == 8'(g))     q <= wdata_i;
    end
    assign cfg_o[g*DW +: DW] = q;
  end
endmodule

// File: rtl/otp_burn_ctrl.sv
module otp_burn_ctrl
  import otp_seq_pkg::*;
#(
  parameter int WAIT_CYCLES = 250_000_000,
  localparam int TW = $clog2(WAIT_CYCLES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  ptr_t       fuse_ptr_i,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       out_en_i,
  output ptr_t       ptr_o,
  output logic       unlock_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       otp_wr_o,
  output logic [1:0] otp_wr_bank_o
);
  localparam logic [TW-1:0] TMR_INIT = TW'(WAIT_CYCLES - 1);

  ptr_t          ptr_q;
  logic          unlock_q, busy_q, done_q, wr_q;
  logic [1:0]    bank_q;
  logic [TW-1:0] tmr_q;
  logic          accept;

  assign accept = wr_i && addr_i == ADDR_CMD && wdata_i == CMD_BURN &&
                  unlock_q && !out_en_i && ptr_q != PTR_FULL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      unlock_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      wr_q     <= 1'b0;
      bank_q   <= '0;
      tmr_q    <= '0;
    end else begin
      wr_q <= 1'b0;
      if (load_i) ptr_q <= fuse_ptr_i;
      if (busy_q) begin
        if (tmr_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
      end else if (accept) begin
        busy_q   <= 1'b1;
        done_q   <= 1'b0;
        wr_q     <= 1'b1;
        unlock_q <= 1'b0;
        tmr_q    <= TMR_INIT;
        bank_q   <= bank_of_ptr({ptr_q[1:0], 1'b1});
        ptr_q    <= {ptr_q[1:0], 1'b1};
      end else if (wr_i && addr_i == ADDR_UNLOCK) begin
        unlock_q <= wdata_i[1];
      end
    end
  end

  assign ptr_o         = ptr_q;
  assign unlock_o      = unlock_q;
  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign otp_wr_o      = wr_q;
  assign otp_wr_bank_o = bank_q;
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_seq_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int WAIT_CYCLES = 250_000_000,
  localparam int CW         = NUM_REGS * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          supply_ok_i,
  input  logic          out_en_i,
  input  logic          wr_en_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [2:0]    otp_ptr_i,
  output logic [1:0]    otp_rd_bank_o,
  input  logic [CW-1:0] otp_rdata_i,
  output logic          otp_wr_o,
  output logic [1:0]    otp_wr_bank_o,
  output logic [CW-1:0] otp_wdata_o,
  output logic [CW-1:0] cfg_o,
  output logic          cfg_valid_o,
  output logic          busy_o,
  output logic          done_o
);
  logic valid_q, load, wr_ok, unlock;
  ptr_t ptr;

  assign load  = supply_ok_i && !valid_q;
  assign wr_ok = wr_en_i && valid_q && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_q <= 1'b0;
    else if (load) valid_q <= 1'b1;
  end

  otp_cfg_regs #(.NUM_REGS(NUM_REGS), .DW(8)) u_regs (
    .clk_i, .rst_ni,
    .load_i      (load),
    .load_data_i (otp_rdata_i),
    .wr_i        (wr_ok),
    .addr_i,
    .wdata_i,
    .cfg_o
  );

  otp_burn_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
    .clk_i, .rst_ni,
    .load_i     (load),
    .fuse_ptr_i (otp_ptr_i),
    .wr_i       (wr_ok),
    .addr_i,
    .wdata_i,
    .out_en_i,
    .ptr_o      (ptr),
    .unlock_o   (unlock),
    .busy_o,
    .done_o,
    .otp_wr_o,
    .otp_wr_bank_o
  );

  assign otp_rd_bank_o = bank_of_ptr(otp_ptr_i);
  assign otp_wdata_o   = cfg_o;
  assign cfg_valid_o   = valid_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == 8'(i)) rdata_o = cfg_o[i*8 +: 8];
    case (addr_i)
      ADDR_UNLOCK: rdata_o = {6'b0, unlock, 1'b0};
      ADDR_PTR:    rdata_o = {2'b0, ptr, 3'b0};
      ADDR_STAT:   rdata_o = {5'b0, valid_q, done_o, busy_o};
      default: ;
    endcase
  end
endmodule

// File: rtl/otp_burn_seq_chk.sv
module otp_burn_seq_chk #(
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          supply_ok_i,
  input logic          out_en_i,
  input logic          wr_en_i,
  input logic [7:0]    addr_i,
  input logic          cfg_valid_o,
  input logic          otp_wr_o,
  input logic          busy_o,
  input logic [CW-1:0] cfg_o,
  input logic [2:0]    ptr,
  input logic          unlock
);
  a_r1_no_valid_wo_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_valid_o && !supply_ok_i) |=> !cfg_valid_o);
  a_r3_ptr_thermo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> (ptr == 3'b001 || ptr == 3'b011 || ptr == 3'b111));
  a_r5_burn_needs_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otp_wr_o |-> ($past(unlock) && !$past(out_en_i)));
  a_r5_no_burn_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 8'h2B && ptr == 3'b111) |=> !otp_wr_o);
  a_r6_wr_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otp_wr_o |=> !otp_wr_o);
  a_r6_unlock_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otp_wr_o |-> !unlock);
  a_r7_busy_with_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otp_wr_o |-> busy_o);
  a_r8_cfg_stable_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cfg_o));
endmodule

bind otp_burn_seq otp_burn_seq_chk #(.CW(NUM_REGS * 8)) u_chk (
  .clk_i, .rst_ni, .supply_ok_i, .out_en_i, .wr_en_i, .addr_i,
  .cfg_valid_o, .otp_wr_o, .busy_o, .cfg_o, .ptr, .unlock
);

// File: tb/tb_otp_burn_seq.sv
module tb_otp_burn_seq;
  localparam int NR = 4;
  localparam int CW = NR * 8;
  localparam int WAIT = 20;
  localparam logic [CW-1:0] FACTORY = 32'hA55A_0F3C;

  logic clk = 0, rst_n = 0, supply = 0, out_en = 0, wr_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [1:0] rd_bank, wr_bank;
  logic [CW-1:0] otp_rdata, otp_wdata, cfg;
  logic otp_wr, valid, busy, done;
  logic [2:0] fuse_ptr = 3'b001;
  logic [CW-1:0] bank [3];

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  otp_burn_seq #(.NUM_REGS(NR), .WAIT_CYCLES(WAIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply), .out_en_i(out_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .otp_ptr_i(fuse_ptr), .otp_rd_bank_o(rd_bank), .otp_rdata_i(otp_rdata),
    .otp_wr_o(otp_wr), .otp_wr_bank_o(wr_bank), .otp_wdata_o(otp_wdata),
    .cfg_o(cfg), .cfg_valid_o(valid), .busy_o(busy), .done_o(done)
  );

  // fuse store: bits can only be set
  assign otp_rdata = bank[rd_bank];
  initial begin bank[0] = FACTORY; bank[1] = '0; bank[2] = '0; end
  always @(posedge clk) if (otp_wr) begin
    bank[wr_bank] = bank[wr_bank] | otp_wdata;
    fuse_ptr = fuse_ptr | (3'b001 << wr_bank);
  end

  // reference model
  logic [7:0] m_reg [NR];
  logic [2:0] m_ptr;
  logic m_valid, m_unlock, m_busy, m_done, m_wr;
  int m_cnt, m_bank;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_ptr = 0; m_valid = 0; m_unlock = 0; m_busy = 0; m_done = 0; m_wr = 0;
      m_cnt = 0; m_bank = 0;
    end else begin
      m_wr = 0;
      if (!m_valid) begin
        if (supply) begin
          int b;
          b = $countones(fuse_ptr) - 1;
          for (int i = 0; i < NR; i++) m_reg[i] = bank[b][i*8 +: 8];
          m_ptr = fuse_ptr; m_valid = 1;
        end
      end else if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
      end else if (wr_en) begin
        if (addr < NR) m_reg[addr] = wdata;
        else if (addr == 8'h1D) m_unlock = wdata[1];
        else if (addr == 8'h2B && wdata == 8'h15 && m_unlock && !out_en && m_ptr != 3'b111) begin
          m_busy = 1; m_done = 0; m_unlock = 0; m_cnt = WAIT; m_wr = 1;
          m_bank = $countones(m_ptr);
          m_ptr = {m_ptr[1:0], 1'b1};
        end
      end
    end
  end

  function automatic logic [CW-1:0] m_cfg();
    logic [CW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = m_reg[i];
    return v;
  endfunction

  // per-cycle compare (R1 R2 R6 R7 R8)
  always @(negedge clk) if (rst_n && !finished) begin
    checks++;
    if (valid !== m_valid || busy !== m_busy || done !== m_done || otp_wr !== m_wr ||
        cfg !== m_cfg() || (m_wr && wr_bank !== 2'(m_bank))) begin
      fails++;
      $display("FAIL R1/R2/R6/R7/R8 cycle: act v%b b%b d%b w%b bank%0d cfg%h exp v%b b%b d%b w%b bank%0d cfg%h",
               valid, busy, done, otp_wr, wr_bank, cfg,
               m_valid, m_busy, m_done, m_wr, m_bank, m_cfg());
    end
  end

  task automatic chk(input string tag, input logic [CW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; #0.5;
    chk(tag, CW'(rdata), CW'(exp));
  endtask

  task automatic power_cycle();
    @(negedge clk); rst_n = 0; supply = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 no valid before supply", CW'(valid), 0);
    chk("R1 cfg zero before supply", cfg, 0);
    supply = 1;
    @(negedge clk);
    chk("R2 valid after supply", CW'(valid), 1);
  endtask

  task automatic set_regs(input logic [CW-1:0] v);
    for (int i = 0; i < NR; i++) wr(8'(i), v[i*8 +: 8]);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    chk("R4 unlock reset", CW'(dut.rdata_o & 8'h00), 0);
    rd(8'h1D, 8'h00, "R4 unlock clear at reset");
    wr(8'h00, 8'h77);                  // ignored before supply
    chk("R1 write before supply ignored", cfg, 0);
    chk("R1 valid low", CW'(valid), 0);
    supply = 1;
    @(negedge clk);
    chk("R2 factory bank loaded", cfg, FACTORY);
    rd(8'h20, 8'h08, "R3 pointer factory");
    wr(8'h20, 8'hFF);
    rd(8'h20, 8'h08, "R3 pointer read-only");
    set_regs(32'h1122_3344);
    rd(8'h02, 8'h22, "R10 reg2 readback");
    chk("R10 cfg image", cfg, 32'h1122_3344);
    wr(8'h2B, 8'h15);                  // locked
    rd(8'h2C, 8'h04, "R5 locked cmd rejected");
    wr(8'h1D, 8'hFF);
    rd(8'h1D, 8'h02, "R4 unlock bit only");
    out_en = 1;
    wr(8'h2B, 8'h15);
    rd(8'h2C, 8'h04, "R5 enable high rejected");
    out_en = 0;
    wr(8'h2B, 8'h14);
    rd(8'h2C, 8'h04, "R5 wrong cmd rejected");
    wr(8'h2B, 8'h15);                  // accepted
    rd(8'h2C, 8'h05, "R7 busy status");
    rd(8'h1D, 8'h00, "R6 unlock cleared");
    rd(8'h20, 8'h18, "R6 pointer advanced");
    wr(8'h00, 8'hEE);
    chk("R8 write while busy ignored", cfg, 32'h1122_3344);
    repeat (WAIT) @(negedge clk);
    rd(8'h2C, 8'h06, "R7 done after wait");
    power_cycle();
    chk("R9 bank1 restored", cfg, 32'h1122_3344);
    rd(8'h20, 8'h18, "R2 pointer 011 loaded");
    set_regs(32'hC0DE_5A01);
    wr(8'h1D, 8'h02);
    wr(8'h2B, 8'h15);
    repeat (WAIT + 2) @(negedge clk);
    power_cycle();
    chk("R9 bank2 restored", cfg, 32'hC0DE_5A01);
    rd(8'h20, 8'h38, "R3 pointer full");
    wr(8'h1D, 8'h02);
    wr(8'h2B, 8'h15);
    rd(8'h2C, 8'h04, "R5 full pointer rejected");
    chk("R5 bank0 untouched", bank[0], FACTORY);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule